// File: doc/BRIEF.md
# Clock Trim Correction Unit

This block divides an oscillator tick stream down to a one-cycle, once-per-second enable for a calendar core. It also corrects the crystal's rate error. A programmed trim byte gives a signed number of correction steps. Each step is two oscillator ticks. The correction is applied once per correction interval by shortening or lengthening the first second of that interval. Positive steps shorten that second, so the timebase runs faster. Negative steps lengthen it.

The interval is normally a set number of seconds (20 by default). The top trim bit has one of two meanings, chosen by a strap pin that is sampled together with the byte:
- It stretches the interval to a longer fine-resolution period (60 seconds by default), which gives three times finer steps.
- It selects an alternate 32.000 kHz crystal, so the divider's base terminal count drops from 32767 to 31999.

Trim bytes arrive on a valid/ready port. The port never applies back-pressure: `trim_ready` is high at all times, and every byte presented with `trim_valid` is taken on that clock edge. An accepted byte is held as pending and becomes active only at the next interval boundary, so a second is never altered partway through. If several bytes arrive within one interval, the last one wins.

Top module: `clk_trim_unit`

## Requirements
- R1: While reset is asserted `sec_pulse` stays low. After release the configuration is cleared: no correction, normal interval, base crystal. The first pulse follows exactly BASE_TC+1 counted ticks.
- R2: With no correction in a second, consecutive `sec_pulse` events are exactly BASE_TC+1 ticks apart, and each pulse is high for a single cycle.
- R3: If bit 6 of the trim byte is 0 and bits 5:1 are not all zero, the step count is c = bits[5:0] - 1 (from +1 to +62). The first second of each interval is then 2*c ticks shorter.
- R4: If bit 6 is 1 and bits 5:1 are not all zero, the step count is c = -((~bits[5:0] & 63) + 1) (from -1 to -62). The first second of each interval is then 2*|c| ticks longer.
- R5: A byte whose bits 5:1 are all zero gives no correction, whatever bit 6 holds.
- R6: With normal resolution, the correction interval is COARSE_SECS seconds. The corrected second is the first one, and the others have the nominal length.
- R7: If `trim_msb_fine` was 1 when the byte was accepted and bit 7 is 1, the interval is FINE_SECS seconds instead.
- R8: If `trim_msb_fine` was 0 when the byte was accepted and bit 7 is 1, every second uses base count ALT_TC. The nominal second is then ALT_TC+1 ticks, and the correction still applies to the first second.
- R9: An accepted byte changes nothing until the next interval boundary. Every remaining second of the current interval keeps the old configuration.
- R10: Only cycles with `osc_tick` high advance the divider. Second lengths are measured in ticks, not clock cycles.
- R11: `trim_ready` is high whenever the block is out of reset. When several bytes are accepted within one interval, the last one is the one applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle enable per oscillator count |
| trim_valid | input | 1 | Trim byte is presented |
| trim_ready | output | 1 | Trim byte can be taken (always high) |
| trim_data | input | 8 | Trim byte: [5:0] count, [6] decrement, [7] mode |
| trim_msb_fine | input | 1 | 1: bit 7 means fine interval; 0: bit 7 means alternate crystal |
| sec_pulse | output | 1 | Single-cycle corrected 1 Hz enable |

## Verification
`sec_pulse` is registered. It rises on the clock edge that counts the terminal tick of a second, so the bench reads it at the falling edge after that tick. It measures each second as the number of counted ticks since the previous pulse. A byte is accepted on the edge after `trim_valid` is driven. It has no visible effect until the first pulse that closes the current interval, and the second that follows that pulse is the first one corrected. The bench's own model advances its interval index and its active and pending settings only when it sees a pulse. It sends each byte right after a pulse, so an accept edge never falls on a boundary edge, and every second is compared against the length due at that moment.

// File: rtl/clk_trim_pkg.sv
package clk_trim_pkg;

  localparam int STEP_W    = 7;
  localparam int MAX_STEPS = 62;

  typedef struct packed {
    logic signed [STEP_W-1:0] steps;  // signed correction steps
    logic                     fine;   // stretched interval
    logic                     alt;    // alternate crystal base count
  } trim_cfg_t;

  localparam trim_cfg_t CFG_NONE = '{steps: '0, fine: 1'b0, alt: 1'b0};

endpackage

// File: rtl/clk_trim_decode.sv
module clk_trim_decode
  import clk_trim_pkg::*;
(
  input  logic [7:0] code,
  input  logic       msb_fine,
  output trim_cfg_t  cfg
);

  logic [5:0]        cnt;
  logic              dec;
  logic [STEP_W-1:0] dec_mag;

  assign cnt     = code[5:0];
  assign dec     = code[6];
  assign dec_mag = {1'b0, ~cnt} + 7'd1;

  always_comb begin
    cfg = CFG_NONE;
    if (cnt[5:1] != 5'd0) begin
      if (dec) cfg.steps = -$signed(dec_mag);
      else     cfg.steps = $signed({1'b0, cnt}) - 7'sd1;
    end
    cfg.fine = code[7] & msb_fine;
    cfg.alt  = code[7] & ~msb_fine;
  end

endmodule

// File: rtl/clk_trim_interval.sv
module clk_trim_interval
  import clk_trim_pkg::*;
#(
  parameter int COARSE_SECS = 20,
  parameter int FINE_SECS   = 60
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sec_end,
  input  logic      load_valid,
  input  trim_cfg_t load_cfg,
  output trim_cfg_t active,
  output logic      first_sec
);

  localparam int MAX_SECS = (FINE_SECS > COARSE_SECS) ? FINE_SECS : COARSE_SECS;
  localparam int SEC_W    = $clog2(MAX_SECS);

  trim_cfg_t        pending;
  logic [SEC_W-1:0] sec_idx;
  logic [SEC_W-1:0] last_idx;
  logic             at_last;

  assign last_idx  = active.fine ? SEC_W'(FINE_SECS - 1) : SEC_W'(COARSE_SECS - 1);
  assign at_last   = (sec_idx == last_idx);
  assign first_sec = (sec_idx == '0);

  // Latest accepted byte waits here until the boundary.
  always_ff @(posedge clk) begin
    if (!rst_n)          pending <= CFG_NONE;
    else if (load_valid) pending <= load_cfg;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sec_idx <= '0;
      active  <= CFG_NONE;
    end else if (sec_end) begin
      if (at_last) begin
        sec_idx <= '0;
        active  <= pending;
      end else begin
        sec_idx <= sec_idx + 1'b1;
      end
    end
  end

  // R9: configuration only moves when a second closes
  p_cfg_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_end |=> $stable(active));

  // R6: index never passes the interval end
  p_idx_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sec_idx <= last_idx);

  // R7: fine interval wraps after its last second
  p_fine_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_end && active.fine && sec_idx == SEC_W'(FINE_SECS - 1)) |=> (sec_idx == '0));

endmodule

// File: rtl/clk_trim_divider.sv
module clk_trim_divider
  import clk_trim_pkg::*;
#(
  parameter int BASE_TC = 32767,
  parameter int ALT_TC  = 31999,
  parameter int DIV_W   = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      osc_tick,
  input  trim_cfg_t active,
  input  logic      first_sec,
  output logic      sec_end,
  output logic      sec_pulse
);

  localparam int CW = DIV_W + 2;

  logic [DIV_W-1:0]     div_cnt;
  logic [DIV_W-1:0]     term;
  logic signed [CW-1:0] base_s;
  logic signed [CW-1:0] adj_s;
  logic signed [CW-1:0] term_s;

  // Terminal count for the current second; correction only in the first.
  always_comb begin
    base_s = active.alt ? CW'(ALT_TC) : CW'(BASE_TC);
    adj_s  = first_sec ? CW'(active.steps) : '0;
    term_s = base_s - (adj_s <<< 1);
    term   = DIV_W'(term_s);
  end

  assign sec_end = osc_tick && (div_cnt == term);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt   <= '0;
      sec_pulse <= 1'b0;
    end else begin
      sec_pulse <= sec_end;
      if (osc_tick) begin
        if (sec_end) div_cnt <= '0;
        else         div_cnt <= div_cnt + 1'b1;
      end
    end
  end

  // R10: no tick, no movement
  p_hold_no_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_tick |=> $stable(div_cnt));

  // R2: counter never runs past the terminal of its second
  p_cnt_le_term_r2: assert property (@(posedge clk) disable iff (!rst_n)
    div_cnt <= term);

  // R3/R4: corrected terminal stays positive
  p_term_positive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    term_s > 0);

endmodule

// File: rtl/clk_trim_unit.sv
module clk_trim_unit
  import clk_trim_pkg::*;
#(
  parameter int BASE_TC     = 32767,
  parameter int ALT_TC      = 31999,
  parameter int COARSE_SECS = 20,
  parameter int FINE_SECS   = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic       trim_valid,
  output logic       trim_ready,
  input  logic [7:0] trim_data,
  input  logic       trim_msb_fine,
  output logic       sec_pulse
);

  localparam int DIV_W = $clog2(BASE_TC + 2 * MAX_STEPS + 1);

  trim_cfg_t dec_cfg;
  trim_cfg_t active;
  logic      first_sec;
  logic      sec_end;
  logic      accept;

  assign trim_ready = 1'b1;
  assign accept     = trim_valid && trim_ready;

  clk_trim_decode u_decode (
    .code     (trim_data),
    .msb_fine (trim_msb_fine),
    .cfg      (dec_cfg)
  );

  clk_trim_interval #(
    .COARSE_SECS (COARSE_SECS),
    .FINE_SECS   (FINE_SECS)
  ) u_interval (
    .clk        (clk),
    .rst_n      (rst_n),
    .sec_end    (sec_end),
    .load_valid (accept),
    .load_cfg   (dec_cfg),
    .active     (active),
    .first_sec  (first_sec)
  );

  clk_trim_divider #(
    .BASE_TC (BASE_TC),
    .ALT_TC  (ALT_TC),
    .DIV_W   (DIV_W)
  ) u_divider (
    .clk       (clk),
    .rst_n     (rst_n),
    .osc_tick  (osc_tick),
    .active    (active),
    .first_sec (first_sec),
    .sec_end   (sec_end),
    .sec_pulse (sec_pulse)
  );

  // R2: the enable is one cycle wide
  p_pulse_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse |=> !sec_pulse);

  // R3/R4: decoded step count within the legal range
  p_steps_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    trim_valid |-> (dec_cfg.steps <= 7'sd62 && dec_cfg.steps >= -7'sd62));

  // R5: zero field in bits 5:1 decodes to no correction
  p_zero_field_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (trim_valid && trim_data[5:1] == 5'd0) |-> (dec_cfg.steps == '0));

endmodule

// File: tb/clk_trim_unit_tb.sv
module clk_trim_unit_tb;

  localparam int BASE_TC = 199;
  localparam int ALT_TC  = 159;
  localparam int COARSE  = 4;
  localparam int FINE    = 6;
  localparam int NVEC    = 14;

  // {alt, fine, steps[7:0], msb_fine, trim[7:0]}
  localparam logic [18:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 8'h00, 1'b0, 8'h00},  // R5
    {1'b0, 1'b0, 8'h00, 1'b0, 8'h01},  // R5
    {1'b0, 1'b0, 8'h00, 1'b0, 8'h41},  // R5 decrement with zero field
    {1'b0, 1'b0, 8'h01, 1'b0, 8'h02},  // R3 +1
    {1'b0, 1'b0, 8'h3E, 1'b0, 8'h3F},  // R3 +62
    {1'b0, 1'b0, 8'h0F, 1'b0, 8'h10},  // R3 +15
    {1'b0, 1'b0, 8'hFF, 1'b0, 8'h7F},  // R4 -1
    {1'b0, 1'b0, 8'hC2, 1'b0, 8'h42},  // R4 -62
    {1'b0, 1'b0, 8'hE0, 1'b0, 8'h60},  // R4 -32
    {1'b1, 1'b0, 8'h04, 1'b0, 8'h85},  // R8 +4
    {1'b0, 1'b1, 8'hC8, 1'b1, 8'hC8},  // R7 -56
    {1'b0, 1'b1, 8'h09, 1'b1, 8'h8A},  // R7 +9
    {1'b1, 1'b0, 8'h3E, 1'b0, 8'hBF},  // R8 +62
    {1'b0, 1'b1, 8'h00, 1'b1, 8'h80}   // R7 no correction
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_tick = 1'b1;
  logic       trim_valid = 1'b0;
  logic       trim_ready;
  logic [7:0] trim_data = 8'h00;
  logic       trim_msb_fine = 1'b0;
  logic       sec_pulse;

  int n_chk = 0;
  int n_bad = 0;
  int ticks = 0, last_ticks = 0, pulses = 0, gcnt = 0;
  bit prev_tick = 1'b1, prev_pulse = 1'b0, gate = 1'b0, first_after_rst = 1'b1;
  int m_steps = 0, p_steps = 0, m_idx = 0;
  bit m_fine = 0, m_alt = 0, p_fine = 0, p_alt = 0;

  always #10 clk = ~clk;

  clk_trim_unit #(
    .BASE_TC     (BASE_TC),
    .ALT_TC      (ALT_TC),
    .COARSE_SECS (COARSE),
    .FINE_SECS   (FINE)
  ) u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .osc_tick      (osc_tick),
    .trim_valid    (trim_valid),
    .trim_ready    (trim_ready),
    .trim_data     (trim_data),
    .trim_msb_fine (trim_msb_fine),
    .sec_pulse     (sec_pulse)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic on_pulse();
    int    exp, gap, n;
    string tag;
    check(!prev_pulse, "R2 pulse width", 1, 0);
    exp = (m_alt ? ALT_TC + 1 : BASE_TC + 1) - ((m_idx == 0) ? 2 * m_steps : 0);
    gap = ticks - last_ticks;
    if (first_after_rst)                tag = "R1 first second";
    else if (gate)                      tag = "R10 gated ticks";
    else if (m_idx == 0 && m_steps > 0) tag = "R3 shortened second";
    else if (m_idx == 0 && m_steps < 0) tag = "R4 lengthened second";
    else if (m_idx == 0)                tag = "R5 uncorrected first second";
    else if (m_alt)                     tag = "R8 alternate crystal";
    else if (m_fine)                    tag = "R7 fine interval";
    else if (p_steps != m_steps)        tag = "R9 pending not yet active";
    else                                tag = "R6 nominal second in interval";
    check(gap == exp, tag, gap, exp);
    first_after_rst = 1'b0;
    last_ticks = ticks;
    n = m_fine ? FINE : COARSE;
    if (m_idx == n - 1) begin
      m_idx = 0; m_steps = p_steps; m_fine = p_fine; m_alt = p_alt;
    end else begin
      m_idx++;
    end
    pulses++;
  endtask

  task automatic step();
    @(negedge clk);
    if (prev_tick) ticks++;
    if (sec_pulse) on_pulse();
    prev_pulse = sec_pulse;
    osc_tick = gate ? ((gcnt % 3) != 0) : 1'b1;
    gcnt++;
    prev_tick = osc_tick;
  endtask

  task automatic run_pulses(input int n);
    int target;
    target = pulses + n;
    while (pulses < target) step();
  endtask

  task automatic send_trim(input logic [7:0] code, input bit msbf,
                           input int steps, input bit fine, input bit alt);
    trim_data = code; trim_msb_fine = msbf; trim_valid = 1'b1;
    step();
    trim_valid = 1'b0;
    p_steps = steps; p_fine = fine; p_alt = alt;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; trim_valid = 1'b0; gate = 1'b0; osc_tick = 1'b1;
    repeat (3) begin
      @(negedge clk);
      check(sec_pulse == 1'b0, "R1 pulse low in reset", sec_pulse, 0);
    end
    rst_n = 1'b1;
    ticks = 0; last_ticks = 0; prev_pulse = 1'b0; prev_tick = 1'b1;
    first_after_rst = 1'b1;
    m_steps = 0; p_steps = 0; m_idx = 0;
    m_fine = 0; m_alt = 0; p_fine = 0; p_alt = 0;
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();
    step();
    check(trim_ready == 1'b1, "R11 ready after reset", trim_ready, 1);
    run_pulses(COARSE + 1);

    // Table walk: each byte sent just after a pulse, then two long intervals.
    for (int i = 0; i < NVEC; i++) begin
      send_trim(VEC[i][7:0], VEC[i][8], int'($signed(VEC[i][16:9])),
                VEC[i][17], VEC[i][18]);
      run_pulses(2 * FINE + 2);
    end

    // R11: two bytes within one interval, last wins; R9 deferral covered by model.
    send_trim(8'h05, 1'b0, 4, 1'b0, 1'b0);
    run_pulses(1);
    check(trim_ready == 1'b1, "R11 ready mid-run", trim_ready, 1);
    send_trim(8'h4A, 1'b0, -54, 1'b0, 1'b0);
    run_pulses(2 * COARSE + 2);

    // R10: gated ticks with a correction active.
    send_trim(8'h14, 1'b0, 19, 1'b0, 1'b0);
    run_pulses(COARSE + 1);
    gate = 1'b1;
    run_pulses(2 * COARSE + 1);
    gate = 1'b0;
    run_pulses(1);

    // R1: reset mid-run clears a live correction.
    send_trim(8'h3F, 1'b0, 62, 1'b0, 1'b0);
    run_pulses(COARSE + 2);
    do_reset();
    run_pulses(COARSE + 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule